// File: doc/BRIEF.md
# Trap and privilege control unit

This unit holds the privilege state of a simple 32-bit processor and sequences every control transfer into the kernel. The pipeline reports, for the instruction in its trap-detection stage, any synchronous fault, a system-call instruction, a privileged instruction, a return-from-exception instruction, a data access and its address. The unit also watches a level-sensitive device interrupt line and its own periodic tick timer. When a trap is taken, a single clock edge does all of the following: it latches the trapping PC and a 4-bit cause, saves the user stack pointer and the previous privilege bit, loads the kernel stack pointer, sets kernel mode, masks further traps, and redirects fetch to the handler vector.

A return-from-exception in kernel mode undoes that switch in one step. It restores the saved privilege bit, stack pointer and PC, and re-enables traps. Kernel software reaches the trap PC, the cause, the tick period, the kernel stack pointer, the saved privilege bit and the saved user stack pointer through a small register-move port. Any use of that port in user mode is a privilege violation. The same holds for a user-mode access at or above the kernel base address.

Top module: `trap_ctl`

## Requirements
- R1: After reset, the unit is in kernel mode (mode_o=1) with traps enabled. flush_o, redirect_valid_o and sp_load_o are 0, and epc_o, cause_o and csr_rdata_o read 0.
- R2: A taken trap shows on the next cycle as follows: epc_o holds the pc_i of the trap cycle, cause_o holds the cause, mode_o is 1, and redirect_valid_o is 1 with redirect_pc_o = 0x80000180. flush_o is 1 for exactly that one cycle.
- R3: In the same cycle as R2, sp_load_o is 1 and sp_val_o carries the kernel stack pointer. The sp_i value and the previous mode are saved for the return.
- R4: eret_i in kernel mode gives, on the next cycle, redirect_valid_o=1 with redirect_pc_o set to the saved PC, sp_load_o=1 with sp_val_o set to the saved stack pointer, and mode_o set to the saved mode. Traps are re-enabled and flush_o stays 0.
- R5: While a trap is being handled (from entry until a kernel eret), no new trap is taken. A synchronous fault or system call raised in that window is dropped. A pending tick or a held interrupt is taken once traps are re-enabled.
- R6: Writing a nonzero N to the tick period (select 2) raises a tick request every N cycles, with cause 1. The first request arrives N cycles after the write, and the trap is taken one cycle later. Writing 0 stops the ticks.
- R7: syscall_i traps with cause 8.
- R8: In user mode, three events raise a trap. A data access with mem_addr_i >= 0x80000000 traps with cause 3. priv_instr_i, eret_i or csr_acc_i each trap with cause 4.
- R9: When several requests coincide, the order is: a reported fault (exc_valid_i), then a privilege violation, then a bad address, then a system call, then a tick, then the interrupt (cause 0).
- R10: The register-move port works only in kernel mode. csr_acc_i reads the register at csr_sel_i into csr_rdata_o on the next cycle, and csr_wr_i writes it. The selects are: 0 trap PC, 1 cause, 2 tick period, 3 kernel SP, 4 saved mode (bit 0), 5 saved SP. A user-mode write changes nothing, because it traps.
- R11: A reported fault takes its cause from exc_code_i. The fault codes are 2 page fault, 5 overflow and 6 divide by zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_i | input | 32 | PC of the instruction in the trap stage |
| sp_i | input | 32 | Current stack pointer value |
| exc_valid_i | input | 1 | Synchronous fault reported by the datapath |
| exc_code_i | input | 4 | Cause code of the reported fault |
| syscall_i | input | 1 | System-call instruction |
| priv_instr_i | input | 1 | Privileged instruction being executed |
| eret_i | input | 1 | Return-from-exception instruction |
| mem_access_i | input | 1 | Data access this cycle |
| mem_addr_i | input | 32 | Data access address |
| irq_i | input | 1 | Device interrupt, level |
| csr_acc_i | input | 1 | Register-move access |
| csr_wr_i | input | 1 | Register-move write (with csr_acc_i) |
| csr_sel_i | input | 3 | Register select |
| csr_wdata_i | input | 32 | Register write data |
| csr_rdata_o | output | 32 | Register read data |
| mode_o | output | 1 | Privilege bit, 1 = kernel |
| flush_o | output | 1 | Squash younger instructions |
| redirect_valid_o | output | 1 | Fetch redirect strobe |
| redirect_pc_o | output | 32 | Fetch redirect target |
| sp_load_o | output | 1 | Stack pointer load strobe |
| sp_val_o | output | 32 | Stack pointer value to load |
| epc_o | output | 32 | Saved trap PC |
| cause_o | output | 4 | Cause of the last trap |

## Verification
Several properties are checked on every cycle. Trap entry always lands in kernel mode with traps masked, the flush pulse and the vector redirect. The captured PC always equals the PC of the trap cycle. Masked traps are never taken, and a kernel return restores the saved mode. The bench scenarios cover what needs a known history: the exact stack pointer values exchanged on entry and return, the full priority ladder, the cycle spacing of timer ticks, and the fact that a pending interrupt or tick survives a masked window while dropped faults do not.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef enum logic [3:0] {
    CAUSE_IRQ     = 4'd0,
    CAUSE_TICK    = 4'd1,
    CAUSE_PGFAULT = 4'd2,
    CAUSE_BADADDR = 4'd3,
    CAUSE_PRIV    = 4'd4,
    CAUSE_OVF     = 4'd5,
    CAUSE_DIV0    = 4'd6,
    CAUSE_SYSCALL = 4'd8
  } cause_e;

  typedef enum logic [2:0] {
    SEL_EPC    = 3'd0,
    SEL_CAUSE  = 3'd1,
    SEL_PERIOD = 3'd2,
    SEL_KSP    = 3'd3,
    SEL_SMODE  = 3'd4,
    SEL_SSP    = 3'd5
  } csr_sel_e;
endpackage

// File: rtl/trap_tick_timer.sv
module trap_tick_timer #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [XLEN-1:0] wdata,
  input  logic            clr_pend,
  output logic [XLEN-1:0] period,
  output logic            pend
);
  logic [XLEN-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      period <= '0;
      cnt    <= '0;
      pend   <= 1'b0;
    end else begin
      if (clr_pend) pend <= 1'b0;
      if (wr_en) begin
        period <= wdata;
        cnt    <= '0;
      end else if (period != '0) begin
        if (cnt == period - 1'b1) begin
          cnt  <= '0;
          pend <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/trap_prio.sv
module trap_prio
  import trap_pkg::*;
#(
  parameter int              XLEN  = 32,
  parameter logic [XLEN-1:0] KBASE = 32'h8000_0000
) (
  input  logic            mode,
  input  logic            trap_en,
  input  logic            exc_valid,
  input  logic [3:0]      exc_code,
  input  logic            syscall,
  input  logic            priv_instr,
  input  logic            eret,
  input  logic            csr_acc,
  input  logic            mem_access,
  input  logic [XLEN-1:0] mem_addr,
  input  logic            tick_pend,
  input  logic            irq,
  output logic            take,
  output logic [3:0]      code,
  output logic            tick_sel,
  output logic            eret_ok
);
  logic priv_bad, addr_bad;

  always_comb begin
    priv_bad = !mode && (priv_instr || eret || csr_acc);
    addr_bad = !mode && mem_access && (mem_addr >= KBASE);
    take     = 1'b0;
    code     = CAUSE_IRQ;
    tick_sel = 1'b0;
    if (trap_en) begin
      if (exc_valid) begin
        take = 1'b1; code = exc_code;
      end else if (priv_bad) begin
        take = 1'b1; code = CAUSE_PRIV;
      end else if (addr_bad) begin
        take = 1'b1; code = CAUSE_BADADDR;
      end else if (syscall) begin
        take = 1'b1; code = CAUSE_SYSCALL;
      end else if (tick_pend) begin
        take = 1'b1; code = CAUSE_TICK; tick_sel = 1'b1;
      end else if (irq) begin
        take = 1'b1; code = CAUSE_IRQ;
      end
    end
    eret_ok = eret && mode && !take;
  end
endmodule

// File: rtl/trap_state.sv
module trap_state
  import trap_pkg::*;
#(
  parameter int              XLEN = 32,
  parameter logic [XLEN-1:0] VEC  = 32'h8000_0180
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take,
  input  logic [3:0]      code,
  input  logic            eret_ok,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] sp,
  input  logic            csr_acc,
  input  logic            csr_wr,
  input  logic [2:0]      csr_sel,
  input  logic [XLEN-1:0] csr_wdata,
  input  logic [XLEN-1:0] period,
  output logic            period_wr,
  output logic            mode,
  output logic            trap_en,
  output logic            saved_mode,
  output logic [XLEN-1:0] epc,
  output logic [3:0]      cause,
  output logic [XLEN-1:0] csr_rdata,
  output logic            flush,
  output logic            redirect_valid,
  output logic [XLEN-1:0] redirect_pc,
  output logic            sp_load,
  output logic [XLEN-1:0] sp_val
);
  logic [XLEN-1:0] saved_sp, ksp, rd_mux;
  logic            wr_ok;

  assign wr_ok     = csr_acc && csr_wr && mode && !take;
  assign period_wr = wr_ok && (csr_sel == SEL_PERIOD);

  always_comb begin
    case (csr_sel)
      SEL_EPC:    rd_mux = epc;
      SEL_CAUSE:  rd_mux = {{(XLEN-4){1'b0}}, cause};
      SEL_PERIOD: rd_mux = period;
      SEL_KSP:    rd_mux = ksp;
      SEL_SMODE:  rd_mux = {{(XLEN-1){1'b0}}, saved_mode};
      SEL_SSP:    rd_mux = saved_sp;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode           <= 1'b1;
      trap_en        <= 1'b1;
      saved_mode     <= 1'b0;
      epc            <= '0;
      cause          <= '0;
      saved_sp       <= '0;
      ksp            <= '0;
      csr_rdata      <= '0;
      flush          <= 1'b0;
      redirect_valid <= 1'b0;
      redirect_pc    <= '0;
      sp_load        <= 1'b0;
      sp_val         <= '0;
    end else begin
      flush          <= 1'b0;
      redirect_valid <= 1'b0;
      sp_load        <= 1'b0;
      csr_rdata      <= (csr_acc && mode) ? rd_mux : '0;
      if (take) begin
        epc            <= pc;
        cause          <= code;
        saved_sp       <= sp;
        saved_mode     <= mode;
        mode           <= 1'b1;
        trap_en        <= 1'b0;
        flush          <= 1'b1;
        redirect_valid <= 1'b1;
        redirect_pc    <= VEC;
        sp_load        <= 1'b1;
        sp_val         <= ksp;
      end else begin
        if (eret_ok) begin
          mode           <= saved_mode;
          trap_en        <= 1'b1;
          redirect_valid <= 1'b1;
          redirect_pc    <= epc;
          sp_load        <= 1'b1;
          sp_val         <= saved_sp;
        end
        if (wr_ok) begin
          case (csr_sel)
            SEL_EPC:   epc        <= csr_wdata;
            SEL_CAUSE: cause      <= csr_wdata[3:0];
            SEL_KSP:   ksp        <= csr_wdata;
            SEL_SMODE: saved_mode <= csr_wdata[0];
            SEL_SSP:   saved_sp   <= csr_wdata;
            default:   ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/trap_ctl.sv
module trap_ctl #(
  parameter int              XLEN  = 32,
  parameter logic [XLEN-1:0] VEC   = 32'h8000_0180,
  parameter logic [XLEN-1:0] KBASE = 32'h8000_0000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] sp_i,
  input  logic            exc_valid_i,
  input  logic [3:0]      exc_code_i,
  input  logic            syscall_i,
  input  logic            priv_instr_i,
  input  logic            eret_i,
  input  logic            mem_access_i,
  input  logic [XLEN-1:0] mem_addr_i,
  input  logic            irq_i,
  input  logic            csr_acc_i,
  input  logic            csr_wr_i,
  input  logic [2:0]      csr_sel_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  output logic [XLEN-1:0] csr_rdata_o,
  output logic            mode_o,
  output logic            flush_o,
  output logic            redirect_valid_o,
  output logic [XLEN-1:0] redirect_pc_o,
  output logic            sp_load_o,
  output logic [XLEN-1:0] sp_val_o,
  output logic [XLEN-1:0] epc_o,
  output logic [3:0]      cause_o
);
  logic            take, tick_sel, eret_ok, trap_en, saved_mode;
  logic            tick_pend, period_wr;
  logic [3:0]      code;
  logic [XLEN-1:0] period;

  trap_tick_timer #(.XLEN(XLEN)) timer_i (
    .clk(clk), .rst(rst), .wr_en(period_wr), .wdata(csr_wdata_i),
    .clr_pend(take && tick_sel), .period(period), .pend(tick_pend)
  );

  trap_prio #(.XLEN(XLEN), .KBASE(KBASE)) prio_i (
    .mode(mode_o), .trap_en(trap_en), .exc_valid(exc_valid_i),
    .exc_code(exc_code_i), .syscall(syscall_i), .priv_instr(priv_instr_i),
    .eret(eret_i), .csr_acc(csr_acc_i), .mem_access(mem_access_i),
    .mem_addr(mem_addr_i), .tick_pend(tick_pend), .irq(irq_i),
    .take(take), .code(code), .tick_sel(tick_sel), .eret_ok(eret_ok)
  );

  trap_state #(.XLEN(XLEN), .VEC(VEC)) state_i (
    .clk(clk), .rst(rst), .take(take), .code(code), .eret_ok(eret_ok),
    .pc(pc_i), .sp(sp_i), .csr_acc(csr_acc_i), .csr_wr(csr_wr_i),
    .csr_sel(csr_sel_i), .csr_wdata(csr_wdata_i), .period(period),
    .period_wr(period_wr), .mode(mode_o), .trap_en(trap_en),
    .saved_mode(saved_mode), .epc(epc_o), .cause(cause_o),
    .csr_rdata(csr_rdata_o), .flush(flush_o),
    .redirect_valid(redirect_valid_o), .redirect_pc(redirect_pc_o),
    .sp_load(sp_load_o), .sp_val(sp_val_o)
  );
endmodule

// File: rtl/trap_ctl_chk.sv
module trap_ctl_chk #(
  parameter int              XLEN = 32,
  parameter logic [XLEN-1:0] VEC  = 32'h8000_0180
) (
  input logic            clk,
  input logic            rst,
  input logic            take,
  input logic            trap_en,
  input logic            eret_ok,
  input logic            saved_mode,
  input logic            mode_o,
  input logic            flush_o,
  input logic            redirect_valid_o,
  input logic [XLEN-1:0] redirect_pc_o,
  input logic [XLEN-1:0] epc_o,
  input logic [XLEN-1:0] pc_i,
  input logic [3:0]      cause_o,
  input logic            csr_acc_i,
  input logic            exc_valid_i
);
  // R2
  entry_mode_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> (mode_o && flush_o && !trap_en));

  // R2
  vector_chk: assert property (@(posedge clk) disable iff (rst)
    flush_o |-> (redirect_valid_o && redirect_pc_o == VEC));

  // R2
  epc_capture_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> (epc_o == $past(pc_i)));

  // R2
  flush_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    flush_o |=> !flush_o);

  // R5
  masked_chk: assert property (@(posedge clk) disable iff (rst)
    !trap_en |-> !take);

  // R4
  eret_mode_chk: assert property (@(posedge clk) disable iff (rst)
    eret_ok |=> (mode_o == $past(saved_mode) && trap_en && !flush_o));

  // R8
  user_csr_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode_o && trap_en && csr_acc_i && !exc_valid_i) |=> (cause_o == 4'd4));
endmodule

bind trap_ctl trap_ctl_chk #(.XLEN(XLEN), .VEC(VEC)) chk_i (
  .clk(clk), .rst(rst), .take(take), .trap_en(trap_en), .eret_ok(eret_ok),
  .saved_mode(saved_mode), .mode_o(mode_o), .flush_o(flush_o),
  .redirect_valid_o(redirect_valid_o), .redirect_pc_o(redirect_pc_o),
  .epc_o(epc_o), .pc_i(pc_i), .cause_o(cause_o), .csr_acc_i(csr_acc_i),
  .exc_valid_i(exc_valid_i)
);

// File: tb/trap_ctl_tb_top.sv
`timescale 1ns/1ps
module trap_ctl_tb_top;
  localparam logic [31:0] VEC = 32'h8000_0180;
  localparam logic [31:0] KSP = 32'h8fff_f000;

  logic        clk = 1'b0, rst = 1'b1;
  logic [31:0] pc_i, sp_i, mem_addr_i, csr_wdata_i;
  logic        exc_valid_i, syscall_i, priv_instr_i, eret_i, mem_access_i;
  logic        irq_i, csr_acc_i, csr_wr_i;
  logic [3:0]  exc_code_i;
  logic [2:0]  csr_sel_i;
  logic [31:0] csr_rdata_o, redirect_pc_o, sp_val_o, epc_o;
  logic        mode_o, flush_o, redirect_valid_o, sp_load_o;
  logic [3:0]  cause_o;
  int n_vec = 0, n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  trap_ctl dut_i (
    .clk(clk), .rst(rst), .pc_i(pc_i), .sp_i(sp_i),
    .exc_valid_i(exc_valid_i), .exc_code_i(exc_code_i),
    .syscall_i(syscall_i), .priv_instr_i(priv_instr_i), .eret_i(eret_i),
    .mem_access_i(mem_access_i), .mem_addr_i(mem_addr_i), .irq_i(irq_i),
    .csr_acc_i(csr_acc_i), .csr_wr_i(csr_wr_i), .csr_sel_i(csr_sel_i),
    .csr_wdata_i(csr_wdata_i), .csr_rdata_o(csr_rdata_o), .mode_o(mode_o),
    .flush_o(flush_o), .redirect_valid_o(redirect_valid_o),
    .redirect_pc_o(redirect_pc_o), .sp_load_o(sp_load_o),
    .sp_val_o(sp_val_o), .epc_o(epc_o), .cause_o(cause_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    exc_valid_i = 0; exc_code_i = 0; syscall_i = 0; priv_instr_i = 0;
    eret_i = 0; mem_access_i = 0; mem_addr_i = 0; irq_i = 0;
    csr_acc_i = 0; csr_wr_i = 0; csr_sel_i = 0; csr_wdata_i = 0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic csr_write(input logic [2:0] sel, input logic [31:0] val);
    csr_acc_i = 1; csr_wr_i = 1; csr_sel_i = sel; csr_wdata_i = val;
    step(); idle();
  endtask

  task automatic csr_read(input logic [2:0] sel, output logic [31:0] val);
    csr_acc_i = 1; csr_sel_i = sel;
    step(); val = csr_rdata_o; idle();
  endtask

  task automatic do_eret();
    eret_i = 1; step(); idle();
  endtask

  task automatic t_reset();
    chk("R1 mode", mode_o, 1);
    chk("R1 flush", flush_o, 0);
    chk("R1 redirect", redirect_valid_o, 0);
    chk("R1 spload", sp_load_o, 0);
    chk("R1 epc", epc_o, 0);
    chk("R1 cause", cause_o, 0);
  endtask

  task automatic t_boot();
    logic [31:0] rd;
    csr_write(3'd0, 32'h0040_0000);
    csr_write(3'd5, 32'h7fff_fff0);
    csr_write(3'd4, 32'h0);
    csr_write(3'd3, KSP);
    csr_read(3'd0, rd);
    chk("R10 read epc", rd, 32'h0040_0000);
    csr_read(3'd3, rd);
    chk("R10 read ksp", rd, KSP);
    do_eret();
    chk("R4 mode", mode_o, 0);
    chk("R4 redirect", redirect_valid_o, 1);
    chk("R4 target", redirect_pc_o, 32'h0040_0000);
    chk("R4 spload", sp_load_o, 1);
    chk("R4 spval", sp_val_o, 32'h7fff_fff0);
    chk("R4 noflush", flush_o, 0);
    step();
    chk("R4 redirect drops", redirect_valid_o, 0);
  endtask

  task automatic t_syscall_roundtrip();
    pc_i = 32'h0040_0010; sp_i = 32'h7fff_ff00; syscall_i = 1;
    step(); idle();
    chk("R2 flush", flush_o, 1);
    chk("R2 vector", redirect_pc_o, VEC);
    chk("R2 epc", epc_o, 32'h0040_0010);
    chk("R2 mode", mode_o, 1);
    chk("R7 cause", cause_o, 8);
    chk("R3 spload", sp_load_o, 1);
    chk("R3 kernel sp", sp_val_o, KSP);
    pc_i = 32'h8000_0180; sp_i = KSP;
    step();
    chk("R2 flush one cycle", flush_o, 0);
    do_eret();
    chk("R3 mode restored", mode_o, 0);
    chk("R3 pc restored", redirect_pc_o, 32'h0040_0010);
    chk("R3 sp restored", sp_val_o, 32'h7fff_ff00);
  endtask

  task automatic t_priority();
    pc_i = 32'h0040_0020;
    exc_valid_i = 1; exc_code_i = 4'd6; priv_instr_i = 1; mem_access_i = 1;
    mem_addr_i = 32'h8000_0004; syscall_i = 1; irq_i = 1;
    step(); idle();
    chk("R9 R11 fault first", cause_o, 6);
    do_eret();
    priv_instr_i = 1; mem_access_i = 1; mem_addr_i = 32'h8000_0004;
    syscall_i = 1; irq_i = 1;
    step(); idle();
    chk("R9 priv before addr", cause_o, 4);
    do_eret();
    mem_access_i = 1; mem_addr_i = 32'h8000_0000; syscall_i = 1; irq_i = 1;
    step(); idle();
    chk("R8 R9 bad address", cause_o, 3);
    do_eret();
    mem_access_i = 1; mem_addr_i = 32'h7fff_fffc; syscall_i = 1; irq_i = 1;
    step(); idle();
    chk("R9 syscall before irq", cause_o, 8);
    do_eret();
    irq_i = 1;
    step(); idle();
    chk("R9 irq alone", cause_o, 0);
    do_eret();
    exc_valid_i = 1; exc_code_i = 4'd2;
    step(); idle();
    chk("R11 page fault code", cause_o, 2);
    do_eret();
  endtask

  task automatic t_user_violations();
    logic [31:0] rd;
    pc_i = 32'h0040_0030;
    csr_acc_i = 1; csr_wr_i = 1; csr_sel_i = 3'd0; csr_wdata_i = 32'hdead_beef;
    step(); idle();
    chk("R8 user csr traps", cause_o, 4);
    csr_read(3'd0, rd);
    chk("R10 user write ignored", rd, 32'h0040_0030);
    do_eret();
    chk("R8 back in user", mode_o, 0);
    pc_i = 32'h0040_0034; eret_i = 1;
    step(); idle();
    chk("R8 user eret traps", cause_o, 4);
    chk("R8 user eret kernel", mode_o, 1);
    do_eret();
  endtask

  task automatic t_masking();
    pc_i = 32'h0040_0040; syscall_i = 1;
    step(); idle();
    pc_i = 32'h8000_0190;
    exc_valid_i = 1; exc_code_i = 4'd5;
    step(); idle();
    chk("R5 fault masked", flush_o, 0);
    chk("R5 cause kept", cause_o, 8);
    syscall_i = 1;
    step(); idle();
    chk("R5 syscall masked", flush_o, 0);
    irq_i = 1;
    for (int i = 0; i < 3; i++) step();
    chk("R5 irq held", flush_o, 0);
    chk("R5 epc kept", epc_o, 32'h0040_0040);
    eret_i = 1; step(); eret_i = 0;
    chk("R5 eret no flush", flush_o, 0);
    chk("R5 eret to user", mode_o, 0);
    pc_i = 32'h0040_0100;
    step(); irq_i = 0;
    chk("R5 pending irq taken", flush_o, 1);
    chk("R5 irq cause", cause_o, 0);
    chk("R5 irq epc", epc_o, 32'h0040_0100);
    do_eret();
  endtask

  task automatic t_timer();
    int cnt;
    syscall_i = 1; step(); idle();
    csr_write(3'd2, 32'd5);
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      eret_i = (i == 0);
      step(); idle(); cnt++;
      if (flush_o) break;
    end
    chk("R6 first tick delay", cnt, 6);
    chk("R6 tick cause", cause_o, 1);
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      eret_i = (i == 0);
      step(); idle(); cnt++;
      if (flush_o) break;
    end
    chk("R6 tick period", cnt, 5);
    csr_write(3'd2, 32'd0);
    do_eret();
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      step();
      if (flush_o) cnt++;
    end
    chk("R6 disabled", cnt, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=hang expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    idle();
    pc_i = 0; sp_i = 0;
    repeat (3) step();
    rst = 0;
    step();
    t_reset();
    t_boot();
    t_syscall_roundtrip();
    t_priority();
    t_user_violations();
    t_masking();
    t_timer();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule